// File: doc/BRIEF.md
# Video Line Timing Sequencer

This block produces the horizontal and vertical timing skeleton for a video-mode serial display link. It counts horizontal time in lane byte clock cycles and vertical time in whole lines. For each cycle it reports which region of the line and which region of the frame it is in: sync, back porch, active or front porch. It also pulses a strobe at the start of every line and at the start of every frame, and drives horizontal sync, vertical sync and data enable. Each of those three outputs has its own polarity select.

The horizontal axis is configured by four values: the sync width, the back porch width, the number of active cycles and the total line time. The front porch is whatever remains of the line after the other three. The vertical axis is configured by four line counts, one per region, and the frame length is their sum.

All configuration inputs are captured into a shadow set only at a frame boundary. A set whose active-line count is above the supported limit is refused as a whole. Packet assembly, the PHY and the pixel path are handled elsewhere.

Top module: `vid_line_sequencer`

## Requirements
- R1: While reset is held, and on the first clock edge after it is released, both region outputs read 3 and both strobes are low. The sync and enable outputs are low during this time. The first frame starts on the cycle after that first edge.
- R2: A line lasts the captured total line time in clock cycles. The horizontal region code follows positions 0 onward in this order: code 0 (sync) for the sync width, code 1 (back porch) for the back porch width, code 2 (active) for the active count, and code 3 (front porch) for the rest. Any region that would run past the total line time is cut off at the line end.
- R3: The line strobe is high on the first cycle of every line. The frame strobe is high only on the first cycle of the first line of a frame.
- R4: The vertical region code changes only at line starts. Within a frame it goes through sync lines (0), back porch lines (1), active lines (2) and front porch lines (3), then wraps to the next frame.
- R5: A region configured with length zero is skipped and adds no cycle or line.
- R6: Horizontal sync is asserted in the horizontal sync region of every line. Vertical sync is asserted throughout the vertical sync lines. Data enable is asserted only where both region codes are 2.
- R7: Polarity select bit 0 controls data enable, bit 1 controls vertical sync and bit 2 controls horizontal sync. A bit set to 1 makes that output active-low.
- R8: A change on any configuration input, polarity included, takes effect only on the first cycle of the next frame.
- R9: A configuration set whose active-line count exceeds VACT_MAX (2047 by default) is refused as a whole at the frame boundary, and the previously captured set stays in use. A count equal to VACT_MAX is accepted.
- R10: A total line time of 0 behaves as a one-cycle line. A frame whose four line counts sum to 0 behaves as a one-line frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hsync_len | input | HW | Horizontal sync width in cycles |
| cfg_hback_len | input | HW | Horizontal back porch width in cycles |
| cfg_hline_len | input | HW | Total line time in cycles |
| cfg_hact_len | input | PW | Active cycles per line |
| cfg_vsync_lines | input | VW | Vertical sync line count |
| cfg_vback_lines | input | VW | Vertical back porch line count |
| cfg_vact_lines | input | VW | Active line count |
| cfg_vfront_lines | input | VW | Vertical front porch line count |
| cfg_pol_low | input | 3 | Active-low selects: bit0 enable, bit1 vsync, bit2 hsync |
| hregion_o | output | 2 | Current horizontal region code |
| vregion_o | output | 2 | Current vertical region code |
| frame_start_o | output | 1 | First cycle of a frame |
| line_start_o | output | 1 | First cycle of a line |
| hsync_o | output | 1 | Horizontal sync with selected polarity |
| vsync_o | output | 1 | Vertical sync with selected polarity |
| de_o | output | 1 | Data enable with selected polarity |

## Verification
The bound checker checks the following on every cycle:
- the idle state before the first frame;
- the frame strobe never occurring without the line strobe;
- the horizontal region never moving backwards inside a line;
- the vertical region holding between line starts and only advancing inside a frame;
- the sync and enable outputs never asserting outside their regions;
- the captured active-line count never exceeding the limit;
- the shadow set staying still except at frame starts.

Exact region lengths, truncation at the line end, skipped zero-length regions, the polarity mapping and the refusal of an oversized set can only be shown by the bench's scenarios. Those scenarios compare against a cycle-level model and count active lines per frame.

// File: rtl/vls_pkg.sv
package vls_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef enum logic [1:0] {
      RG_SYNC   = 2'd0,
      RG_BACK   = 2'd1,
      RG_ACTIVE = 2'd2,
      RG_FRONT  = 2'd3
   } region_e;

   // Region of a position given three leading region lengths; the
   // remainder of the axis is the front porch.
   function automatic region_e locate(input logic [31:0] pos,
                                      input logic [31:0] l_sync,
                                      input logic [31:0] l_back,
                                      input logic [31:0] l_act);
      logic [31:0] e_back, e_act;
      e_back = l_sync + l_back;
      e_act  = e_back + l_act;
      if (pos < l_sync)      return RG_SYNC;
      else if (pos < e_back) return RG_BACK;
      else if (pos < e_act)  return RG_ACTIVE;
      else                   return RG_FRONT;
   endfunction
endpackage

// File: rtl/vls_shadow.sv
module vls_shadow #(
   parameter int HW       = 16,
   parameter int PW       = 14,
   parameter int VW       = 12,
   parameter int VACT_MAX = 2047,
   parameter int NPOL     = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [HW-1:0]   in_hsa,
   input  logic [HW-1:0]   in_hbp,
   input  logic [HW-1:0]   in_hline,
   input  logic [PW-1:0]   in_hact,
   input  logic [VW-1:0]   in_vsa,
   input  logic [VW-1:0]   in_vbp,
   input  logic [VW-1:0]   in_vact,
   input  logic [VW-1:0]   in_vfp,
   input  logic [NPOL-1:0] in_pol,
   output logic [HW-1:0]   sh_hsa,
   output logic [HW-1:0]   sh_hbp,
   output logic [HW-1:0]   sh_hline,
   output logic [PW-1:0]   sh_hact,
   output logic [VW-1:0]   sh_vsa,
   output logic [VW-1:0]   sh_vbp,
   output logic [VW-1:0]   sh_vact,
   output logic [VW-1:0]   sh_vfp,
   output logic [NPOL-1:0] sh_pol
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [VW-1:0] VLIM = VW'(VACT_MAX);

   if (VACT_MAX >= (1 << VW)) begin : g_bad_limit
      $error("VACT_MAX does not fit in VW bits");
   end

   logic accept;
   assign accept = (in_vact <= VLIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_hsa   <= '0;
         sh_hbp   <= '0;
         sh_hline <= '0;
         sh_hact  <= '0;
         sh_vsa   <= '0;
         sh_vbp   <= '0;
         sh_vact  <= '0;
         sh_vfp   <= '0;
         sh_pol   <= '0;
      end else if (load && accept) begin
         sh_hsa   <= in_hsa;
         sh_hbp   <= in_hbp;
         sh_hline <= in_hline;
         sh_hact  <= in_hact;
         sh_vsa   <= in_vsa;
         sh_vbp   <= in_vbp;
         sh_vact  <= in_vact;
         sh_vfp   <= in_vfp;
         sh_pol   <= in_pol;
      end
   end
endmodule

// File: rtl/vls_axis.sv
module vls_axis
   import vls_pkg::*;
#(
   parameter int SW = 16,
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [SW-1:0] len_sync,
   input  logic [SW-1:0] len_back,
   input  logic [SW-1:0] len_act,
   input  logic [TW-1:0] total,
   output logic [TW-1:0] pos,
   output region_e       region,
   output logic          last
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int CW = TW + 1;

   if (TW > 30 || SW > 28) begin : g_bad_width
      $error("axis widths exceed the region decoder range");
   end

   logic [CW-1:0] nxt;
   assign nxt  = {1'b0, pos} + CW'(1);
   // A total of zero also ends the axis after a single step.
   assign last = (nxt >= {1'b0, total});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pos <= '0;
      else if (step) pos <= last ? '0 : nxt[TW-1:0];
   end

   always_comb region = locate(32'(pos), 32'(len_sync), 32'(len_back), 32'(len_act));
endmodule

// File: rtl/vls_polar.sv
module vls_polar #(
   parameter int N = 3
) (
   input  logic [N-1:0] raw,
   input  logic [N-1:0] low_sel,
   output logic [N-1:0] pin
);
   timeunit 1ns;
   timeprecision 100ps;

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign pin[i] = raw[i] ^ low_sel[i];
   end
endmodule

// File: rtl/vid_line_sequencer.sv
module vid_line_sequencer
   import vls_pkg::*;
#(
   parameter int HW       = 16,
   parameter int PW       = 14,
   parameter int VW       = 12,
   parameter int VACT_MAX = 2047
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [HW-1:0] cfg_hsync_len,
   input  logic [HW-1:0] cfg_hback_len,
   input  logic [HW-1:0] cfg_hline_len,
   input  logic [PW-1:0] cfg_hact_len,
   input  logic [VW-1:0] cfg_vsync_lines,
   input  logic [VW-1:0] cfg_vback_lines,
   input  logic [VW-1:0] cfg_vact_lines,
   input  logic [VW-1:0] cfg_vfront_lines,
   input  logic [2:0]    cfg_pol_low,
   output logic [1:0]    hregion_o,
   output logic [1:0]    vregion_o,
   output logic          frame_start_o,
   output logic          line_start_o,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          de_o
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int VTW  = VW + 2;
   localparam int NPOL = 3;

   if (PW > HW) begin : g_bad_pw
      $error("active count width must not exceed horizontal width");
   end

   logic            run_q;
   logic [HW-1:0]   sh_hsa, sh_hbp, sh_hline;
   logic [PW-1:0]   sh_hact;
   logic [VW-1:0]   sh_vsa, sh_vbp, sh_vact, sh_vfp;
   logic [NPOL-1:0] sh_pol;
   logic [HW-1:0]   hpos;
   logic [VTW-1:0]  vpos, vtotal;
   region_e         hreg, vreg;
   logic            hlast, vlast, load;
   logic [NPOL-1:0] raw;

   assign load = ~run_q | (hlast & vlast);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   vls_shadow #(.HW(HW), .PW(PW), .VW(VW), .VACT_MAX(VACT_MAX), .NPOL(NPOL)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(load),
      .in_hsa(cfg_hsync_len), .in_hbp(cfg_hback_len), .in_hline(cfg_hline_len),
      .in_hact(cfg_hact_len), .in_vsa(cfg_vsync_lines), .in_vbp(cfg_vback_lines),
      .in_vact(cfg_vact_lines), .in_vfp(cfg_vfront_lines), .in_pol(cfg_pol_low),
      .sh_hsa(sh_hsa), .sh_hbp(sh_hbp), .sh_hline(sh_hline), .sh_hact(sh_hact),
      .sh_vsa(sh_vsa), .sh_vbp(sh_vbp), .sh_vact(sh_vact), .sh_vfp(sh_vfp),
      .sh_pol(sh_pol)
   );

   assign vtotal = VTW'(sh_vsa) + VTW'(sh_vbp) + VTW'(sh_vact) + VTW'(sh_vfp);

   vls_axis #(.SW(HW), .TW(HW)) u_hax (
      .clk(clk), .rst_n(rst_n), .step(run_q),
      .len_sync(sh_hsa), .len_back(sh_hbp), .len_act(HW'(sh_hact)),
      .total(sh_hline), .pos(hpos), .region(hreg), .last(hlast)
   );

   vls_axis #(.SW(VW), .TW(VTW)) u_vax (
      .clk(clk), .rst_n(rst_n), .step(run_q & hlast),
      .len_sync(sh_vsa), .len_back(sh_vbp), .len_act(sh_vact),
      .total(vtotal), .pos(vpos), .region(vreg), .last(vlast)
   );

   assign line_start_o  = run_q & (hpos == '0);
   assign frame_start_o = line_start_o & (vpos == '0);
   assign hregion_o     = run_q ? hreg : RG_FRONT;
   assign vregion_o     = run_q ? vreg : RG_FRONT;

   assign raw[0] = run_q & (hreg == RG_ACTIVE) & (vreg == RG_ACTIVE);
   assign raw[1] = run_q & (vreg == RG_SYNC);
   assign raw[2] = run_q & (hreg == RG_SYNC);

   vls_polar #(.N(NPOL)) u_pol (.raw(raw), .low_sel(sh_pol), .pin({hsync_o, vsync_o, de_o}));
endmodule

// File: rtl/vls_chk.sv
module vls_chk
   import vls_pkg::*;
#(
   parameter int VW       = 12,
   parameter int VACT_MAX = 2047
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic [1:0]    hregion,
   input logic [1:0]    vregion,
   input logic          frame_start,
   input logic          line_start,
   input logic          hsync,
   input logic          vsync,
   input logic          de,
   input logic [2:0]    pol,
   input logic [VW-1:0] sh_vact
);
   timeunit 1ns;
   timeprecision 100ps;

   // R1
   idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!line_start && !frame_start && hregion == RG_FRONT && vregion == RG_FRONT));

   // R3
   frame_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> line_start);

   // R2
   hregion_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |-> (hregion >= $past(hregion)));

   // R4
   vregion_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |-> $stable(vregion));

   // R4
   vregion_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !frame_start && $past(run)) |-> (vregion >= $past(vregion)));

   // R6
   hsync_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync ^ pol[2]) |-> (hregion == RG_SYNC));

   // R6
   de_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (de ^ pol[0]) |-> (hregion == RG_ACTIVE && vregion == RG_ACTIVE && !(vsync ^ pol[1])));

   // R8
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !frame_start) |-> ($stable(pol) && $stable(sh_vact)));

   // R9
   vact_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sh_vact) <= 32'(VACT_MAX));
endmodule

bind vid_line_sequencer vls_chk #(.VW(VW), .VACT_MAX(VACT_MAX)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_q),
   .hregion(hregion_o), .vregion(vregion_o),
   .frame_start(frame_start_o), .line_start(line_start_o),
   .hsync(hsync_o), .vsync(vsync_o), .de(de_o),
   .pol(sh_pol), .sh_vact(sh_vact)
);

// File: tb/tb_vid_line_sequencer.sv
module tb_vid_line_sequencer;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int HW = 16, PW = 14, VW = 12, VACT_MAX = 2047;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [HW-1:0] c_hs = '0, c_hbp = '0, c_hl = '0;
   logic [PW-1:0] c_pkt = '0;
   logic [VW-1:0] c_vs = '0, c_vbp = '0, c_vact = '0, c_vfp = '0;
   logic [2:0]    c_pol = '0;
   logic [1:0]    hregion_o, vregion_o;
   logic          frame_start_o, line_start_o, hsync_o, vsync_o, de_o;

   int    checks = 0, fails = 0;
   bit    cmp_on = 0, done = 0;
   string phase = "R1";

   // reference model state
   int m_run = 0, m_h = 0, m_v = 0;
   int s_hs = 0, s_hbp = 0, s_hl = 0, s_pkt = 0;
   int s_vs = 0, s_vbp = 0, s_vact = 0, s_vfp = 0, s_pol = 0;

   always #2.5 clk = ~clk;

   vid_line_sequencer #(.HW(HW), .PW(PW), .VW(VW), .VACT_MAX(VACT_MAX)) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_hsync_len(c_hs), .cfg_hback_len(c_hbp), .cfg_hline_len(c_hl), .cfg_hact_len(c_pkt),
      .cfg_vsync_lines(c_vs), .cfg_vback_lines(c_vbp), .cfg_vact_lines(c_vact),
      .cfg_vfront_lines(c_vfp), .cfg_pol_low(c_pol),
      .hregion_o(hregion_o), .vregion_o(vregion_o), .frame_start_o(frame_start_o),
      .line_start_o(line_start_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o)
   );

   task automatic model_capture();
      if (int'(c_vact) <= VACT_MAX) begin
         s_hs = int'(c_hs); s_hbp = int'(c_hbp); s_hl = int'(c_hl); s_pkt = int'(c_pkt);
         s_vs = int'(c_vs); s_vbp = int'(c_vbp); s_vact = int'(c_vact); s_vfp = int'(c_vfp);
         s_pol = int'(c_pol);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_h = 0; m_v = 0;
         s_hs = 0; s_hbp = 0; s_hl = 0; s_pkt = 0;
         s_vs = 0; s_vbp = 0; s_vact = 0; s_vfp = 0; s_pol = 0;
      end else if (m_run == 0) begin
         m_run = 1;
         model_capture();
      end else begin
         int ht, vt;
         ht = (s_hl == 0) ? 1 : s_hl;
         vt = s_vs + s_vbp + s_vact + s_vfp;
         if (vt == 0) vt = 1;
         if (m_h + 1 >= ht) begin
            m_h = 0;
            if (m_v + 1 >= vt) begin
               m_v = 0;
               model_capture();
            end else m_v = m_v + 1;
         end else m_h = m_h + 1;
      end
   end

   function automatic int region_of(int p, int a, int b, int c);
      if (p < a) return 0;
      if (p < a + b) return 1;
      if (p < a + b + c) return 2;
      return 3;
   endfunction

   task automatic check1(string rq, string fld, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s [%s] actual=%0d expected=%0d at %0t", rq, fld, phase, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         int eh, ev, els, efs, rh, rv, rd;
         eh  = (m_run != 0) ? region_of(m_h, s_hs, s_hbp, s_pkt) : 3;
         ev  = (m_run != 0) ? region_of(m_v, s_vs, s_vbp, s_vact) : 3;
         els = (m_run != 0 && m_h == 0) ? 1 : 0;
         efs = (els == 1 && m_v == 0) ? 1 : 0;
         rh  = (m_run != 0 && eh == 0) ? 1 : 0;
         rv  = (m_run != 0 && ev == 0) ? 1 : 0;
         rd  = (m_run != 0 && eh == 2 && ev == 2) ? 1 : 0;
         check1("R2", "hregion", int'(hregion_o), eh);
         check1("R4", "vregion", int'(vregion_o), ev);
         check1("R3", "line_start", int'(line_start_o), els);
         check1("R3", "frame_start", int'(frame_start_o), efs);
         check1("R6", "hsync", int'(hsync_o), rh ^ ((s_pol >> 2) & 1));
         check1("R6", "vsync", int'(vsync_o), rv ^ ((s_pol >> 1) & 1));
         check1("R6", "de", int'(de_o), rd ^ (s_pol & 1));
      end
   end

   task automatic set_cfg(int hs, int hbp, int hl, int pkt, int vs, int vbp, int va, int vf, int pol);
      c_hs = HW'(hs); c_hbp = HW'(hbp); c_hl = HW'(hl); c_pkt = PW'(pkt);
      c_vs = VW'(vs); c_vbp = VW'(vbp); c_vact = VW'(va); c_vfp = VW'(vf); c_pol = 3'(pol);
   endtask

   task automatic count_active(output int n);
      n = 0;
      do @(negedge clk); while (!frame_start_o);
      do begin
         if (line_start_o && vregion_o == 2'd2) n++;
         @(negedge clk);
      end while (!frame_start_o);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired before the scenarios completed");
         finish_run();
      end
   end

   initial begin
      int n;
      // R1: idle state during reset
      set_cfg(3, 4, 20, 8, 2, 2, 5, 3, 0);
      repeat (3) @(negedge clk);
      check1("R1", "hregion in reset", int'(hregion_o), 3);
      check1("R1", "vregion in reset", int'(vregion_o), 3);
      check1("R1", "strobes in reset", int'({frame_start_o, line_start_o}), 0);
      check1("R1", "sync/de in reset", int'({hsync_o, vsync_o, de_o}), 0);
      rst_n = 1'b1;
      cmp_on = 1;
      @(negedge clk);
      check1("R1", "frame_start after first edge", int'(frame_start_o), 1);

      phase = "R2 R3 R4 R6 base";
      repeat (500) @(negedge clk);

      phase = "R7 R8 polarity mid-frame";
      repeat (37) @(negedge clk);
      c_pol = 3'b111;
      repeat (500) @(negedge clk);

      phase = "R5 zero-length regions";
      set_cfg(2, 0, 12, 6, 1, 0, 4, 0, 2);
      repeat (400) @(negedge clk);

      phase = "R2 truncation at line end";
      set_cfg(3, 4, 9, 6, 1, 0, 4, 0, 5);
      repeat (300) @(negedge clk);

      phase = "R9 refused set";
      set_cfg(1, 1, 5, 2, 2, 2, 3000, 2, 0);
      count_active(n);
      check1("R9", "active lines after refused set", n, 4);

      phase = "R9 limit accepted";
      set_cfg(0, 0, 1, 1, 0, 0, VACT_MAX, 0, 1);
      count_active(n);
      check1("R9", "active lines at limit", n, VACT_MAX);

      phase = "R10 zero totals";
      set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
      repeat (2100) @(negedge clk);
      check1("R10", "line_start on one-cycle frame", int'(line_start_o), 1);
      @(negedge clk);
      check1("R10", "frame_start on one-cycle frame", int'(frame_start_o), 1);

      done = 1;
      finish_run();
   end
endmodule